// File: doc/BRIEF.md
# Branch and Skip Sequencer

This block decides where a small microcontroller core fetches its next instruction when the current instruction changes the flow of control. The decoder supplies the current program counter, an instruction class, a signed relative offset, a status-bit selector with the polarity to match, the status flags, a precomputed skip condition, and whether the following instruction occupies two words. The block returns the next program counter, whether the normal sequence was left, and how many clock cycles the instruction takes.

Calls and returns use a small circular return-address stack inside the block. A call saves the address of the instruction after it. A return, or a return from an interrupt handler, restores the most recent saved address. A return from an interrupt also raises a strobe that tells the core to set its global interrupt enable. The ALU, the fetch memory and interrupt arbitration are handled elsewhere.

The instruction class `op_kind` is encoded as 0 = plain sequential, 1 = relative jump, 2 = relative call, 3 = return, 4 = interrupt return, 5 = conditional branch and 6 = skip. Code 7 behaves like 0. The flag bits are 0 = C, 1 = Z, 2 = N, 3 = V, 4 = sign, 5 = H, 6 = T and 7 = I.

Top module: `flow_seq`

## Requirements
- R1: For a relative jump (`op_kind` 1), `pc_next` is `pc_cur + k + 1` modulo 2^PC_W, with `rel_k` sign-extended. `taken` is 1 and `cycles` is 2.
- R2: For a relative call (`op_kind` 2), `pc_next` is `pc_cur + k + 1` (k sign-extended), `taken` is 1 and `cycles` is 3. The value `pc_cur + 1` is pushed onto the return stack at the clock edge.
- R3: For a return (`op_kind` 3), `pc_next` is the most recently pushed address that has not yet been popped, `taken` is 1 and `cycles` is 4. That entry is popped at the clock edge, so nested calls unwind last-in first-out.
- R4: An interrupt return (`op_kind` 4) behaves exactly like a return and also drives `int_en_set` to 1. `int_en_set` is 0 for every other class.
- R5: For a conditional branch (`op_kind` 5) with `bit_sel` other than 4, the branch is taken when `flags[bit_sel]` equals `bit_pol`. A taken branch gives `pc_next = pc_cur + k + 1` with 2 cycles. A branch that is not taken gives `pc_cur + 1` with 1 cycle.
- R6: When `bit_sel` is 4, a branch tests N XOR V, computed from `flags[2]` and `flags[3]`, and ignores `flags[4]`. With `bit_pol` 0 this gives signed greater-or-equal; with `bit_pol` 1 it gives signed less-than.
- R7: For a skip (`op_kind` 6) with `skip_cond` 1, the PC advances by 3 when `next_two_word` is 1 and by 2 otherwise. `cycles` equals that advance and `taken` is 1. With `skip_cond` 0 the PC advances by 1, `cycles` is 1 and `taken` is 0.
- R8: Classes 0 and 7 give `pc_cur + 1`, 1 cycle and `taken` 0, and leave the return stack untouched.
- R9: The return stack holds DEPTH entries in a ring. After more than DEPTH pushes, the oldest entries are overwritten, and after DEPTH pops the stack wraps around to its newest slot.
- R10: Reset clears every stack entry to 0, so a return issued straight after reset yields `pc_next` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_kind | input | 3 | Instruction class |
| pc_cur | input | PC_W | Address of the current instruction |
| rel_k | input | OFS_W | Signed relative offset |
| bit_sel | input | 3 | Status bit tested by a branch |
| bit_pol | input | 1 | Branch when the selected bit equals this value |
| flags | input | 8 | Status flags |
| skip_cond | input | 1 | Skip condition holds |
| next_two_word | input | 1 | The following instruction is two words long |
| pc_next | output | PC_W | Next program counter |
| taken | output | 1 | Sequential flow left |
| cycles | output | 3 | Cycle count of this instruction |
| int_en_set | output | 1 | Strobe to set the global interrupt enable |

## Verification
The branch class is swept over every selector, both polarities and all 256 flag patterns. This separates a wrong bit index, a flipped polarity and a failure to derive the signed test from N and V rather than from the stored sign bit.

Jumps and calls are driven with offsets across the full signed range and with program counters near both ends of the address space. This exposes missing sign extension and missing wrap-around.

Skips are tried with all four combinations of condition and word length. Call and return chains deeper than the stack, plus a return straight after reset, show whether the order is last-in first-out, whether the ring wraps correctly and whether reset clears the entries.

// File: rtl/flow_seq.sv
module flow_seq #(
  parameter int PC_W  = 10,
  parameter int OFS_W = 12,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_kind,
  input  logic [PC_W-1:0]  pc_cur,
  input  logic [OFS_W-1:0] rel_k,
  input  logic [2:0]       bit_sel,
  input  logic             bit_pol,
  input  logic [7:0]       flags,
  input  logic             skip_cond,
  input  logic             next_two_word,
  output logic [PC_W-1:0]  pc_next,
  output logic             taken,
  output logic [2:0]       cycles,
  output logic             int_en_set
);
  localparam int SW    = (PC_W > OFS_W) ? PC_W : OFS_W;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [2:0] K_JMP = 3'd1, K_CALL = 3'd2, K_RET = 3'd3,
                         K_RETI = 3'd4, K_BR = 3'd5, K_SKIP = 3'd6;

  logic signed [SW-1:0] k_ext;
  logic [PC_W-1:0]      pc_inc, pc_rel, pc_skip;
  logic                 flag_bit, br_hit;
  logic [PC_W-1:0]      stk [DEPTH];
  logic [PTR_W-1:0]     ptr, top_idx, push_nxt;

  assign k_ext    = SW'(signed'(rel_k));
  assign pc_inc   = pc_cur + PC_W'(1);
  assign pc_rel   = pc_cur + k_ext[PC_W-1:0] + PC_W'(1);
  assign pc_skip  = pc_cur + (next_two_word ? PC_W'(3) : PC_W'(2));
  assign flag_bit = (bit_sel == 3'd4) ? (flags[2] ^ flags[3]) : flags[bit_sel];
  assign br_hit   = (flag_bit == bit_pol);
  assign top_idx  = (ptr == '0) ? PTR_W'(DEPTH - 1) : ptr - PTR_W'(1);
  assign push_nxt = (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + PTR_W'(1);

  always_comb begin
    pc_next    = pc_inc;
    taken      = 1'b0;
    cycles     = 3'd1;
    int_en_set = 1'b0;
    case (op_kind)
      K_JMP:  begin pc_next = pc_rel; taken = 1'b1; cycles = 3'd2; end
      K_CALL: begin pc_next = pc_rel; taken = 1'b1; cycles = 3'd3; end
      K_RET, K_RETI: begin
        pc_next    = stk[top_idx];
        taken      = 1'b1;
        cycles     = 3'd4;
        int_en_set = (op_kind == K_RETI);
      end
      K_BR: if (br_hit) begin pc_next = pc_rel; taken = 1'b1; cycles = 3'd2; end
      K_SKIP: if (skip_cond) begin
        pc_next = pc_skip;
        taken   = 1'b1;
        cycles  = next_two_word ? 3'd3 : 3'd2;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (op_kind == K_CALL) begin
      stk[ptr] <= pc_inc;
      ptr      <= push_nxt;
    end else if (op_kind == K_RET || op_kind == K_RETI) begin
      ptr <= top_idx;
    end
  end

  AST_RET_AFTER_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == K_RET && $past(op_kind) == K_CALL && $past(rst_n))
      |-> pc_next == $past(pc_cur) + PC_W'(1)); // R3
  AST_SKIP_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == K_SKIP && taken) |-> PC_W'(cycles) == pc_next - pc_cur); // R7
  AST_IDLE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> (pc_next == pc_cur + PC_W'(1) && cycles == 3'd1)); // R8
  AST_IE_ONLY_RETI: assert property (@(posedge clk) disable iff (!rst_n)
    int_en_set |-> (op_kind == K_RETI && taken && cycles == 3'd4)); // R4
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < PTR_W'(DEPTH)); // R9
  AST_BR_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == K_BR) |-> (cycles == (taken ? 3'd2 : 3'd1))); // R5
endmodule

// File: tb/flow_seq_bench.sv
module flow_seq_bench;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  op_kind = 0, bit_sel = 0;
  logic [9:0]  pc_cur = 0;
  logic [11:0] rel_k = 0;
  logic        bit_pol = 0, skip_cond = 0, next_two_word = 0;
  logic [7:0]  flags = 0;
  logic [9:0]  pc_next;
  logic        taken, int_en_set;
  logic [2:0]  cycles;
  int tests = 0, fails = 0;
  logic [9:0] mstk [3];
  int mptr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flow_seq u_flow_seq (.clk, .rst_n, .op_kind, .pc_cur, .rel_k, .bit_sel, .bit_pol,
    .flags, .skip_cond, .next_two_word, .pc_next, .taken, .cycles, .int_en_set);

  task automatic apply(input logic [2:0] kd, input logic [9:0] pc, input logic [11:0] k,
                       input logic [2:0] sel, input logic pol, input logic [7:0] fl,
                       input logic sc, input logic tw);
    @(negedge clk);
    op_kind = kd; pc_cur = pc; rel_k = k; bit_sel = sel; bit_pol = pol;
    flags = fl; skip_cond = sc; next_two_word = tw;
    #2;
  endtask

  task automatic expect_out(input string rq, input logic [9:0] epc, input logic [2:0] ecy,
                            input logic etk, input logic eie);
    tests++;
    if (pc_next !== epc || cycles !== ecy || taken !== etk || int_en_set !== eie) begin
      fails++;
      $display("FAIL %s: pc=%0d cyc=%0d tk=%0d ie=%0d expected pc=%0d cyc=%0d tk=%0d ie=%0d",
               rq, pc_next, cycles, taken, int_en_set, epc, ecy, etk, eie);
    end
  endtask

  function automatic logic [9:0] rel(input logic [9:0] pc, input logic [11:0] k);
    int e;
    int ki;
    ki = $signed(k);
    e = int'(pc) + ki + 1;
    return e[9:0];
  endfunction

  task automatic do_call(input logic [9:0] pc, input logic [11:0] k);
    apply(3'd2, pc, k, 0, 0, 0, 0, 0);
    expect_out("R2 call", rel(pc, k), 3'd3, 1, 0);
    mstk[mptr] = pc + 10'd1;
    mptr = (mptr + 1) % 3;
  endtask

  task automatic do_ret(input bit irq);
    mptr = (mptr + 2) % 3;
    apply(irq ? 3'd4 : 3'd3, 10'd77, 0, 0, 0, 0, 0, 0);
    expect_out(irq ? "R4 reti" : "R3 ret", mstk[mptr], 3'd4, 1, irq);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) mstk[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    apply(3'd0, 10'd5, 0, 0, 0, 0, 0, 0);
    expect_out("R8 reset idle", 10'd6, 3'd1, 0, 0);
    do_ret(0); // R10 cleared stack
    apply(3'd0, 10'd1023, 0, 0, 0, 0, 0, 0);
    expect_out("R8 wrap", 10'd0, 3'd1, 0, 0);
    apply(3'd7, 10'd40, 12'h800, 0, 0, 0, 1, 1);
    expect_out("R8 code7", 10'd41, 3'd1, 0, 0);
    // R1 jumps across offsets and PCs
    for (int p = 0; p < 1024; p += 341)
      for (int k = 0; k < 4096; k += 13) begin
        apply(3'd1, p[9:0], k[11:0], 0, 0, 0, 0, 0);
        expect_out("R1 jump", rel(p[9:0], k[11:0]), 3'd2, 1, 0);
      end
    // R5 R6 branch sweep
    for (int s = 0; s < 8; s++)
      for (int pol = 0; pol < 2; pol++)
        for (int f = 0; f < 256; f++) begin
          logic [7:0] fl;
          logic bv;
          logic [9:0] pc;
          logic [11:0] k;
          fl = f[7:0];
          bv = (s == 4) ? (fl[2] ^ fl[3]) : fl[s];
          pc = 10'(f * 4 + s);
          k = 12'(f * 16 - 2048 + pol);
          apply(3'd5, pc, k, s[2:0], pol[0], fl, 0, 0);
          if (bv == pol[0]) expect_out(s == 4 ? "R6 signed taken" : "R5 taken", rel(pc, k), 3'd2, 1, 0);
          else expect_out(s == 4 ? "R6 signed not taken" : "R5 not taken", pc + 10'd1, 3'd1, 0, 0);
        end
    // R7 skips
    for (int p = 1020; p < 1024; p++)
      for (int c = 0; c < 4; c++) begin
        apply(3'd6, p[9:0], 12'h7FF, 0, 0, 0, c[0], c[1]);
        if (c[0]) expect_out("R7 skip", p[9:0] + (c[1] ? 10'd3 : 10'd2), c[1] ? 3'd3 : 3'd2, 1, 0);
        else expect_out("R7 no skip", p[9:0] + 10'd1, 3'd1, 0, 0);
      end
    // R2 R3 R4 nesting, R9 ring wrap
    do_call(10'd100, 12'd20);
    do_call(10'd200, 12'hFF0);
    apply(3'd0, 10'd9, 0, 0, 0, 0, 0, 0); // R8 no stack change
    expect_out("R8 idle mid", 10'd10, 3'd1, 0, 0);
    do_ret(0);
    do_ret(1);
    for (int i = 0; i < 4; i++) do_call(10'(300 + 50 * i), 12'(i * 100));
    for (int i = 0; i < 5; i++) do_ret(i[0]); // R9
    do_call(10'd1023, 12'hFFF);
    do_ret(1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule